// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches up to eight general-purpose pins that are configured as inputs and turns chosen activity on them into interrupt status. Each pin can be set to react to a held level (high or low), to one chosen edge (rising or falling), or to any change. Detected events are latched in a raw status register until software clears them. A mask selects which latched bits may drive the single combined interrupt request.

Software reaches the block through a simple register port. It has a write strobe, a byte address, write data and combinational read data. The direction vector comes from the surrounding GPIO logic. A pin whose direction bit marks it as an output never produces status. Pins configured for level detection keep setting their status bit on every cycle the active level is present. Clearing such a bit while the level still holds therefore has no lasting effect.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the sense, both-edge, event, mask and raw status registers all read 0 and irqOut is low.
- R2: An input pin with sense bit 0 and both-edge bit 1 sets its raw status bit on the clock edge after any change of its value.
- R3: An input pin with sense bit 0 and both-edge bit 0 sets its status only on a change to the value of its event bit: event 1 selects rising edges and event 0 selects falling edges. The opposite edge sets nothing.
- R4: An input pin with sense bit 1 sets its status bit on every clock edge at which the pin equals its event bit (1 = active high, 0 = active low).
- R5: A pin whose direction bit is 1 (output) never sets its status bit, whatever its mode or value.
- R6: A write to offset 0x41C clears each raw status bit whose written bit is 1 and leaves the others. A detection on the same bit in the same cycle wins over the clear.
- R7: irqOut is high exactly when raw status AND mask is nonzero. Offset 0x414 reads raw status and 0x418 reads raw status AND mask.
- R8: Offsets 0x404 (sense), 0x408 (both-edge), 0x40C (event) and 0x410 (mask) are written and read back as written. Writes to 0x414 and 0x418 change nothing. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Current pin values |
| pinDir | input | 8 | Direction per pin, 1 = output |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte offset |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr |
| irqOut | output | 1 | Combined masked interrupt request |

## Verification
One fixed configuration gives every pin a different mode: active-high level, active-low level, rising, falling, any-edge, any-edge on an output pin, and a second rising and falling pair. A sequence of pin words is then walked through it. The words toggle alternate pins, all pins up and down, hold a value, and drop only the low nibble. Each result therefore tells a rising from a falling detector, an edge from a level detector, and an input from an output pin. Directed cases cover a clear that collides with a fresh edge, partial clears, mask gating of the request, writes to the read-only offsets and reads of unmapped offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_EVENT  = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SENSE,
    RD_BOTH,
    RD_EVENT,
    RD_MASK,
    RD_RAW,
    RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   wrSense;
    logic   wrBoth;
    logic   wrEvent;
    logic   wrMask;
    logic   wrClear;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    unique case (busAddr)
      OFF_SENSE:  begin strb.wrSense = busWrEn; strb.rdSel = RD_SENSE;  end
      OFF_BOTH:   begin strb.wrBoth  = busWrEn; strb.rdSel = RD_BOTH;   end
      OFF_EVENT:  begin strb.wrEvent = busWrEn; strb.rdSel = RD_EVENT;  end
      OFF_MASK:   begin strb.wrMask  = busWrEn; strb.rdSel = RD_MASK;   end
      OFF_RAW:    strb.rdSel = RD_RAW;
      OFF_MASKED: strb.rdSel = RD_MASKED;
      OFF_CLEAR:  strb.wrClear = busWrEn;
      default:    strb.rdSel = RD_NONE;
    endcase
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSense, strb.wrBoth, strb.wrEvent, strb.wrMask, strb.wrClear})) // R8
    else $error("more than one register write strobe");

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> !(strb.wrSense || strb.wrBoth || strb.wrEvent || strb.wrMask || strb.wrClear)) // R8
    else $error("write strobe without bus write");

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinDir,
  input  strobes_t            strb,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] senseReg, bothReg, eventReg, maskReg, statusReg;
  logic [NUM_PINS-1:0] prevIn;
  logic [NUM_PINS-1:0] setVec, clrVec, edgeHit, levelHit;

  // per-pin detection, chosen by the three mode bits
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic isInput, changed, atEvent;
    assign isInput     = !pinDir[i];
    assign changed     = pinIn[i] ^ prevIn[i];
    assign atEvent     = (pinIn[i] == eventReg[i]);
    assign edgeHit[i]  = isInput && !senseReg[i] && changed && (bothReg[i] || atEvent);
    assign levelHit[i] = isInput && senseReg[i] && atEvent;
    assign setVec[i]   = edgeHit[i] || levelHit[i];

    AST_BOTH_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (!pinDir[i] && !senseReg[i] && bothReg[i] && (pinIn[i] != prevIn[i])) |=> statusReg[i]) // R2
      else $error("any-edge change not latched");

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (!pinDir[i] && senseReg[i] && (pinIn[i] == eventReg[i])) |=> statusReg[i]) // R4
      else $error("active level not latched");

    AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (pinDir[i] && !statusReg[i]) |=> !statusReg[i]) // R5
      else $error("output pin set status");

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (statusReg[i] && !(strb.wrClear && wrData[i])) |=> statusReg[i]) // R6
      else $error("status lost without clear");
  end

  assign clrVec = strb.wrClear ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseReg  <= '0;
      bothReg   <= '0;
      eventReg  <= '0;
      maskReg   <= '0;
      statusReg <= '0;
      prevIn    <= '0;
    end else begin
      if (strb.wrSense) senseReg <= wrData;
      if (strb.wrBoth)  bothReg  <= wrData;
      if (strb.wrEvent) eventReg <= wrData;
      if (strb.wrMask)  maskReg  <= wrData;
      statusReg <= (statusReg & ~clrVec) | setVec;
      prevIn    <= pinIn;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_SENSE:  rdData = senseReg;
      RD_BOTH:   rdData = bothReg;
      RD_EVENT:  rdData = eventReg;
      RD_MASK:   rdData = maskReg;
      RD_RAW:    rdData = statusReg;
      RD_MASKED: rdData = statusReg & maskReg;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = |(statusReg & maskReg);

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irqOut) // R7
    else $error("request with empty mask");

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinDir,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  output logic                irqOut
);

  strobes_t strb;

  gpio_irq_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .pinDir (pinDir),
    .strb   (strb),
    .wrData (busWrData),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  pinIn;
  logic [7:0]  pinDir;
  logic        busWrEn;
  logic [11:0] busAddr;
  logic [7:0]  busWrData;
  logic [7:0]  busRdData;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // {pin word, expected raw status}; mode per pin set below
  localparam logic [15:0] VEC_TAB [0:5] = '{
    16'h5557, 16'hAA13, 16'h008A, 16'hFF57, 16'hFF01, 16'hF00B
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readChk(string req, logic [11:0] a, logic [7:0] exp);
    busAddr = a; #1;
    check(req, busRdData, exp);
  endtask

  initial begin
    rstN = 1'b0; pinIn = '0; pinDir = '0;
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    readChk("R1 sense", 12'h404, 8'h00);
    readChk("R1 mask", 12'h410, 8'h00);
    readChk("R1 raw", 12'h414, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    // configuration: p0 level hi, p1 level lo, p2 rise, p3 fall,
    // p4 any, p5 any but output, p6 rise, p7 fall
    pinDir = 8'h20;
    busWr(12'h404, 8'h03);
    busWr(12'h408, 8'h30);
    busWr(12'h40C, 8'h45);
    busWr(12'h410, 8'hFF);
    readChk("R8 sense readback", 12'h404, 8'h03);
    readChk("R8 both readback", 12'h408, 8'h30);
    readChk("R8 event readback", 12'h40C, 8'h45);
    readChk("R8 mask readback", 12'h410, 8'hFF);
    busWr(12'h41C, 8'hFF);   // leaves level-low p1 set

    // table walk: R2 R3 R4 R5 exercised per row
    for (int k = 0; k < 6; k++) begin
      pinIn = VEC_TAB[k][15:8];
      @(posedge clk); @(negedge clk);
      readChk($sformatf("R3/R2/R4/R5 row %0d raw", k), 12'h414, VEC_TAB[k][7:0]);
      check($sformatf("R7 row %0d irq", k), {7'd0, irqOut}, {7'd0, VEC_TAB[k][7:0] != 8'h00});
      busWr(12'h41C, 8'hFF);
    end

    // R6 clear colliding with a rising edge on p2
    busAddr = 12'h41C; busWrData = 8'hFF; busWrEn = 1'b1; pinIn = 8'hF4;
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    readChk("R6 detection beats clear", 12'h414, 8'h06);
    busWr(12'h41C, 8'h02);
    readChk("R6 zero bits untouched", 12'h414, 8'h06);
    busWr(12'h41C, 8'h04);
    readChk("R6 partial clear", 12'h414, 8'h02);

    // R7 mask gating
    busWr(12'h410, 8'h06);
    check("R7 irq with mask", {7'd0, irqOut}, 8'h01);
    readChk("R7 masked read", 12'h418, 8'h02);
    busWr(12'h410, 8'h04);
    check("R7 irq masked off", {7'd0, irqOut}, 8'h00);
    pinIn = 8'hF0; @(posedge clk); @(negedge clk);
    pinIn = 8'hF4; @(posedge clk); @(negedge clk);
    check("R7 irq on rising p2", {7'd0, irqOut}, 8'h01);
    readChk("R7 masked after edge", 12'h418, 8'h04);

    // R5 all pins outputs
    pinDir = 8'hFF;
    busWr(12'h41C, 8'hFF);
    pinIn = 8'h00; @(posedge clk); @(negedge clk);
    pinIn = 8'hFF; @(posedge clk); @(negedge clk);
    readChk("R5 outputs silent", 12'h414, 8'h00);
    check("R5 irq low", {7'd0, irqOut}, 8'h00);

    // R8 read-only and unmapped offsets
    busWr(12'h414, 8'hFF);
    busWr(12'h418, 8'hFF);
    readChk("R8 raw not writable", 12'h414, 8'h00);
    readChk("R8 unmapped reads zero", 12'h420, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule